// File: doc/BRIEF.md
# Frame-Buffered Luma Histogram Equalizer

This block equalizes the brightness of a 4:2:2 video stream whose frames are stored in an external frame buffer and then read back. It sits on two streams. The capture stream is the pixel stream being written to the buffer. The block only taps it: it counts how often each luma code occurs over the whole frame. When the capture stream marks the last pixel of the frame, the block freezes the counts. It then walks the bins one per clock, building a cumulative mapping table, and toggles a sync output. That toggle tells the buffer logic it may replay the frame.

The replay stream is the same frame coming back from the buffer. Each luma sample is replaced by its table entry, so frame N is corrected with the histogram of frame N itself. The chroma sample and the five control markers are delayed by the same single register, so they stay aligned with the luma. A bypass input, sampled per pixel, forwards the raw luma instead.

Two tables are kept. A new frame's table is written into the idle copy and only becomes visible at the next replay frame start, so a frame that is being replayed never sees a half-built table.

Top module: `histeq_framebuf`

## Requirements
- R1: While reset is asserted, and on the first edge after it, `out_valid` is 0 and `frame_sync` is 0.
- R2: For a frame of T valid capture pixels, the table maps luma code k to floor(255 * C(k) / T). Here C(k) is the number of valid pixels of that frame with luma at most k.
- R3: `frame_sync` changes level exactly 256 clock edges after the edge that samples a capture pixel with `wr_valid`, `wr_vend` and `wr_hend` all 1. It changes at no other time.
- R4: A replay pixel presented at edge e appears on `out_y` after edge e, with one cycle of latency. It uses the table that was most recently published when the replay pixel carrying `rd_valid` and `rd_vstart` was sampled.
- R5: `out_c` and the markers `out_valid`, `out_hstart`, `out_hend`, `out_vstart`, `out_vend` equal the replay inputs of the previous edge, unchanged.
- R6: When `bypass` is 1 with a replay pixel, `out_y` one cycle later equals that pixel's `rd_y`.
- R7: A table published while a replay frame is in progress does not change the mapping used for the rest of that replay frame.
- R8: A capture pixel with `wr_vstart` restarts all counts, so a frame's table depends only on that frame's pixels.
- R9: For a frame in which every pixel has luma v, code v and all codes above it map to 255, and codes below v map to 0.
- R10: Capture cycles with `wr_valid` at 0 are not counted, whatever luma and markers they carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Capture pixel valid |
| wr_hend | input | 1 | Capture pixel is last of its line |
| wr_vstart | input | 1 | Capture pixel is first of the frame |
| wr_vend | input | 1 | Capture pixel is in the last line |
| wr_y | input | YW | Capture luma |
| rd_valid | input | 1 | Replay pixel valid |
| rd_hstart | input | 1 | Replay pixel is first of its line |
| rd_hend | input | 1 | Replay pixel is last of its line |
| rd_vstart | input | 1 | Replay pixel is first of the frame |
| rd_vend | input | 1 | Replay pixel is in the last line |
| rd_y | input | YW | Replay luma |
| rd_c | input | CW | Replay chroma (alternating Cb/Cr) |
| bypass | input | 1 | Forward raw luma for this pixel |
| out_valid | output | 1 | Output pixel valid |
| out_hstart | output | 1 | Delayed line start marker |
| out_hend | output | 1 | Delayed line end marker |
| out_vstart | output | 1 | Delayed frame start marker |
| out_vend | output | 1 | Delayed last line marker |
| out_y | output | YW | Equalized (or bypassed) luma |
| out_c | output | CW | Delayed chroma |
| frame_sync | output | 1 | Toggles when a frame's table is published |

## Verification
The mapping is tried with three frames:
- A spread frame with idle cycles carrying junk luma and markers. Its table has many distinct steps, so a wrong rounding, an off-by-one cumulative sum, or counting idle cycles each changes some output code.
- A single-code frame. It collapses the table to a step from 0 to 255 and exposes leftover counts from the previous frame.
- A third frame, captured while the single-code frame is replayed slowly with gaps. Its table is published mid-replay, so a premature bank switch shows up as changed output codes in the second half of that replay.

Bypass is applied to one column only, so it is told apart from a table that happens to be the identity.

// File: rtl/histeq_pkg.sv
package histeq_pkg;

   // Per-pixel control markers carried alongside every sample.
   typedef struct packed {
      logic valid;
      logic hstart;
      logic hend;
      logic vstart;
      logic vend;
   } pixctl_t;

endpackage

// File: rtl/heq_hist.sv
// Luma occurrence counters for one frame; restarted by the first pixel.
module heq_hist #(
   parameter int YW   = 8,
   parameter int CNTW = 21
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            pix_valid,
   input  logic            frame_first,
   input  logic [YW-1:0]   pix_y,
   input  logic [YW-1:0]   rd_idx,
   output logic [CNTW-1:0] rd_cnt,
   output logic [CNTW-1:0] total
);
   localparam int BINS = 1 << YW;

   logic [CNTW-1:0] bin_w [BINS];
   logic [CNTW-1:0] total_q;

   for (genvar b = 0; b < BINS; b++) begin : g_bin
      logic [CNTW-1:0] cnt_q;
      logic            hit;
      assign hit = (pix_y == YW'(b));
      always_ff @(posedge clk) begin
         if (rst) begin
            cnt_q <= '0;
         end else if (pix_valid) begin
            if (frame_first)
               cnt_q <= hit ? CNTW'(1) : '0;
            else if (hit)
               cnt_q <= cnt_q + CNTW'(1);
         end
      end
      assign bin_w[b] = cnt_q;
   end

   always_ff @(posedge clk) begin
      if (rst)
         total_q <= '0;
      else if (pix_valid)
         total_q <= frame_first ? CNTW'(1) : total_q + CNTW'(1);
   end

   assign rd_cnt = bin_w[rd_idx];
   assign total  = total_q;

   // R10
   idle_no_count_chk: assert property (@(posedge clk) disable iff (rst)
      !pix_valid |=> $stable(total_q));

endmodule

// File: rtl/heq_map.sv
// Sequential cumulative-sum walk that fills the idle copy of a
// double-buffered mapping table, then publishes it.
module heq_map #(
   parameter int YW   = 8,
   parameter int CNTW = 21
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start,
   input  logic [CNTW-1:0] hist_cnt,
   input  logic [CNTW-1:0] total,
   output logic [YW-1:0]   hist_idx,
   output logic            pub_bank,
   output logic            sync_tgl,
   input  logic            rd_bank,
   input  logic [YW-1:0]   rd_idx,
   output logic [YW-1:0]   rd_val
);
   localparam int BINS = 1 << YW;
   localparam int MAXV = BINS - 1;
   localparam int PW   = CNTW + YW;

   logic [YW-1:0]   tbl_q [2][BINS];
   logic            run_q, pub_q, sync_q;
   logic [YW-1:0]   idx_q;
   logic [CNTW-1:0] acc_q, acc_nx;
   logic [PW-1:0]   prod_w;
   logic [YW-1:0]   map_val;
   logic            last_w;

   assign acc_nx  = acc_q + hist_cnt;
   assign prod_w  = PW'(acc_nx) * PW'(MAXV);
   assign map_val = YW'(prod_w / PW'(total));
   assign last_w  = (idx_q == YW'(MAXV));

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q  <= 1'b0;
         idx_q  <= '0;
         acc_q  <= '0;
         pub_q  <= 1'b0;
         sync_q <= 1'b0;
      end else if (run_q) begin
         acc_q <= acc_nx;
         idx_q <= idx_q + YW'(1);
         if (last_w) begin
            run_q  <= 1'b0;
            pub_q  <= ~pub_q;
            sync_q <= ~sync_q;
         end
      end else if (start) begin
         run_q <= 1'b1;
         idx_q <= '0;
         acc_q <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (run_q)
         tbl_q[~pub_q][idx_q] <= map_val;
   end

   assign hist_idx = idx_q;
   assign pub_bank = pub_q;
   assign sync_tgl = sync_q;
   assign rd_val   = tbl_q[rd_bank][rd_idx];

   // R2
   cdf_bound_chk: assert property (@(posedge clk) disable iff (rst)
      run_q |-> (acc_nx <= total));
   // R2
   monotone_chk: assert property (@(posedge clk) disable iff (rst)
      (run_q && idx_q != '0) |-> (map_val >= $past(map_val)));
   // R9
   full_scale_chk: assert property (@(posedge clk) disable iff (rst)
      (run_q && last_w) |-> (map_val == YW'(MAXV)));
   // R3
   sync_only_done_chk: assert property (@(posedge clk) disable iff (rst)
      (sync_q != $past(sync_q)) |-> $past(run_q && last_w));

endmodule

// File: rtl/heq_remap.sv
// Replay-side lookup: one register stage for luma, chroma and markers.
module heq_remap
   import histeq_pkg::*;
#(
   parameter int YW = 8,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  pixctl_t       in_ctl,
   input  logic [YW-1:0] in_y,
   input  logic [CW-1:0] in_c,
   input  logic          bypass,
   input  logic          pub_bank,
   output logic          tbl_bank,
   output logic [YW-1:0] tbl_idx,
   input  logic [YW-1:0] tbl_val,
   output pixctl_t       out_ctl,
   output logic [YW-1:0] out_y,
   output logic [CW-1:0] out_c
);
   logic    use_q;
   logic    fstart;
   pixctl_t ctl_q;
   logic [YW-1:0] y_q;
   logic [CW-1:0] c_q;

   assign fstart   = in_ctl.valid & in_ctl.vstart;
   assign tbl_bank = fstart ? pub_bank : use_q;
   assign tbl_idx  = in_y;

   always_ff @(posedge clk) begin
      if (rst) begin
         use_q <= 1'b0;
         ctl_q <= '0;
         y_q   <= '0;
         c_q   <= '0;
      end else begin
         if (fstart)
            use_q <= pub_bank;
         ctl_q <= in_ctl;
         y_q   <= bypass ? in_y : tbl_val;
         c_q   <= in_c;
      end
   end

   assign out_ctl = ctl_q;
   assign out_y   = y_q;
   assign out_c   = c_q;

   // R5
   ctl_delay_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (out_ctl == $past(in_ctl) && out_c == $past(in_c)));
   // R6
   bypass_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(bypass && in_ctl.valid)) |-> (out_y == $past(in_y)));
   // R7
   bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(fstart) |-> $stable(use_q));

endmodule

// File: rtl/histeq_framebuf.sv
module histeq_framebuf
   import histeq_pkg::*;
#(
   parameter int YW         = 8,
   parameter int CW         = 8,
   parameter int MAX_PIXELS = 1920 * 1080
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_valid,
   input  logic          wr_hend,
   input  logic          wr_vstart,
   input  logic          wr_vend,
   input  logic [YW-1:0] wr_y,
   input  logic          rd_valid,
   input  logic          rd_hstart,
   input  logic          rd_hend,
   input  logic          rd_vstart,
   input  logic          rd_vend,
   input  logic [YW-1:0] rd_y,
   input  logic [CW-1:0] rd_c,
   input  logic          bypass,
   output logic          out_valid,
   output logic          out_hstart,
   output logic          out_hend,
   output logic          out_vstart,
   output logic          out_vend,
   output logic [YW-1:0] out_y,
   output logic [CW-1:0] out_c,
   output logic          frame_sync
);
   localparam int CNTW = $clog2(MAX_PIXELS + 1);

   initial begin
      if (YW < 2 || YW > 10)
         $fatal(1, "histeq_framebuf: YW must lie in 2..10");
      if (CW < 1)
         $fatal(1, "histeq_framebuf: CW must be positive");
      if (MAX_PIXELS < 1)
         $fatal(1, "histeq_framebuf: MAX_PIXELS must be positive");
   end

   logic            wr_eof;
   logic [YW-1:0]   h_idx;
   logic [CNTW-1:0] h_cnt, h_total;
   logic            pub_bank, tbl_bank;
   logic [YW-1:0]   tbl_idx, tbl_val;
   pixctl_t         rd_ctl, o_ctl;

   assign wr_eof = wr_valid & wr_vend & wr_hend;
   assign rd_ctl = '{valid: rd_valid, hstart: rd_hstart, hend: rd_hend,
                     vstart: rd_vstart, vend: rd_vend};

   heq_hist #(.YW(YW), .CNTW(CNTW)) u_hist (
      .clk(clk), .rst(rst), .pix_valid(wr_valid), .frame_first(wr_vstart),
      .pix_y(wr_y), .rd_idx(h_idx), .rd_cnt(h_cnt), .total(h_total));

   heq_map #(.YW(YW), .CNTW(CNTW)) u_map (
      .clk(clk), .rst(rst), .start(wr_eof), .hist_cnt(h_cnt), .total(h_total),
      .hist_idx(h_idx), .pub_bank(pub_bank), .sync_tgl(frame_sync),
      .rd_bank(tbl_bank), .rd_idx(tbl_idx), .rd_val(tbl_val));

   heq_remap #(.YW(YW), .CW(CW)) u_remap (
      .clk(clk), .rst(rst), .in_ctl(rd_ctl), .in_y(rd_y), .in_c(rd_c),
      .bypass(bypass), .pub_bank(pub_bank), .tbl_bank(tbl_bank),
      .tbl_idx(tbl_idx), .tbl_val(tbl_val), .out_ctl(o_ctl),
      .out_y(out_y), .out_c(out_c));

   assign out_valid  = o_ctl.valid;
   assign out_hstart = o_ctl.hstart;
   assign out_hend   = o_ctl.hend;
   assign out_vstart = o_ctl.vstart;
   assign out_vend   = o_ctl.vend;

endmodule

// File: tb/sim_histeq_framebuf.sv
`timescale 1ns/1ps
module sim_histeq_framebuf;
   localparam int FW = 8, FH = 4, BLANK = 270, WAIT_PUB = 256;

   logic clk = 1'b0, rst = 1'b1;
   always #2.5 clk = ~clk;

   logic wr_valid = 0, wr_hend = 0, wr_vstart = 0, wr_vend = 0;
   logic [7:0] wr_y = 0;
   logic rd_valid = 0, rd_hstart = 0, rd_hend = 0, rd_vstart = 0, rd_vend = 0;
   logic [7:0] rd_y = 0, rd_c = 0;
   logic bypass = 0;
   logic out_valid, out_hstart, out_hend, out_vstart, out_vend, frame_sync;
   logic [7:0] out_y, out_c;

   histeq_framebuf #(.YW(8), .CW(8), .MAX_PIXELS(1920 * 1080)) u0 (
      .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_hend(wr_hend),
      .wr_vstart(wr_vstart), .wr_vend(wr_vend), .wr_y(wr_y),
      .rd_valid(rd_valid), .rd_hstart(rd_hstart), .rd_hend(rd_hend),
      .rd_vstart(rd_vstart), .rd_vend(rd_vend), .rd_y(rd_y), .rd_c(rd_c),
      .bypass(bypass), .out_valid(out_valid), .out_hstart(out_hstart),
      .out_hend(out_hend), .out_vstart(out_vstart), .out_vend(out_vend),
      .out_y(out_y), .out_c(out_c), .frame_sync(frame_sync));

   int compared = 0, mism = 0, syncs = 0;
   string cur_tag = "R4";

   // behavioural reference state
   int hist[256];
   int pend[256];
   int tbl[2][256];
   int cnt = 0, pub = 0, use_b = 0, cd = 0;
   logic [4:0] e_ctl = 0;
   logic [7:0] e_y = 0, e_c = 0;
   logic e_byp = 0, e_sync = 0, prev_sync = 0;

   always @(posedge clk) begin
      if (rst) begin
         e_ctl = 0; e_y = 0; e_c = 0; e_byp = 0; e_sync = 0;
         pub = 0; use_b = 0; cd = 0; cnt = 0;
      end else begin
         int bk;
         bk = (rd_valid && rd_vstart) ? pub : use_b;
         if (rd_valid && rd_vstart) use_b = pub;
         e_ctl = {rd_valid, rd_hstart, rd_hend, rd_vstart, rd_vend};
         e_byp = bypass && rd_valid;
         e_y   = bypass ? rd_y : 8'(tbl[bk][rd_y]);
         e_c   = rd_c;
         if (cd > 0) begin
            cd--;
            if (cd == 0) begin
               pub = 1 - pub;
               for (int k = 0; k < 256; k++) tbl[pub][k] = pend[k];
               e_sync = ~e_sync;
            end
         end
         if (wr_valid) begin
            if (wr_vstart) begin
               for (int k = 0; k < 256; k++) hist[k] = 0;
               cnt = 0;
            end
            hist[wr_y]++;
            cnt++;
            if (wr_vend && wr_hend) begin
               int acc;
               acc = 0;
               for (int k = 0; k < 256; k++) begin
                  acc += hist[k];
                  pend[k] = (255 * acc) / cnt;
               end
               cd = WAIT_PUB;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (!rst) begin
         logic bad;
         bad = 0;
         compared++;
         if ({out_valid, out_hstart, out_hend, out_vstart, out_vend} !== e_ctl) begin
            bad = 1;
            $display("FAIL R5 markers: actual %b expected %b",
                     {out_valid, out_hstart, out_hend, out_vstart, out_vend}, e_ctl);
         end
         if (out_c !== e_c) begin
            bad = 1;
            $display("FAIL R5 chroma: actual %0d expected %0d", out_c, e_c);
         end
         if (e_ctl[4] && out_y !== e_y) begin
            bad = 1;
            $display("FAIL %s luma: actual %0d expected %0d",
                     e_byp ? "R6" : cur_tag, out_y, e_y);
         end
         if (frame_sync !== e_sync) begin
            bad = 1;
            $display("FAIL R3 sync: actual %b expected %b", frame_sync, e_sync);
         end
         if (bad) mism++;
         if (frame_sync !== prev_sync) syncs++;
         prev_sync = frame_sync;
      end
   end

   function automatic logic [7:0] ypat(input int kind, input int r, input int c);
      case (kind)
         0: return 8'((r * 37 + c * 11 + c * c * 3) & 255);
         1: return 8'd100;
         default: return 8'(255 - ((r * FW + c) * 7));
      endcase
   endfunction

   task automatic wr_px(input logic v, input logic vs, input logic ve,
                        input logic he, input logic [7:0] y);
      @(negedge clk);
      wr_valid = v; wr_vstart = vs; wr_vend = ve; wr_hend = he; wr_y = y;
   endtask

   task automatic write_frame(input int kind, input bit gaps);
      for (int r = 0; r < FH; r++)
         for (int c = 0; c < FW; c++) begin
            wr_px(1, r == 0 && c == 0, r == FH - 1, c == FW - 1, ypat(kind, r, c));
            // R10: idle cycles carrying junk luma and markers
            if (gaps && ((r * FW + c) % 5 == 4)) wr_px(0, 1, 1, 1, 8'hFF);
         end
      wr_px(0, 0, 0, 0, 0);
   endtask

   task automatic idle_wr(input int n);
      for (int i = 0; i < n; i++) wr_px(0, 0, 0, 0, 0);
   endtask

   task automatic read_frame(input int kind, input bit bymask, input int gap);
      for (int r = 0; r < FH; r++)
         for (int c = 0; c < FW; c++) begin
            @(negedge clk);
            rd_valid = 1; rd_hstart = (c == 0); rd_hend = (c == FW - 1);
            rd_vstart = (r == 0 && c == 0); rd_vend = (r == FH - 1);
            rd_y = ypat(kind, r, c); rd_c = 8'(r * FW + c + 1);
            bypass = bymask && (c == 3);
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               rd_valid = 0; rd_hstart = 0; rd_hend = 0; rd_vstart = 0;
               rd_vend = 0; bypass = 0; rd_y = 8'hA5;
            end
         end
      @(negedge clk);
      rd_valid = 0; rd_hstart = 0; rd_hend = 0; rd_vstart = 0; rd_vend = 0;
      bypass = 0; rd_y = 0; rd_c = 0;
      repeat (3) @(negedge clk);
   endtask

   task automatic run_all();
      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         compared++;
         if (out_valid !== 1'b0 || frame_sync !== 1'b0) begin
            mism++;
            $display("FAIL R1 reset: actual valid=%b sync=%b expected 0 0",
                     out_valid, frame_sync);
         end
      end
      rst = 0;
      cur_tag = "R2 R10";
      write_frame(0, 1);
      idle_wr(BLANK);
      cur_tag = "R4";
      read_frame(0, 0, 0);
      cur_tag = "R6";
      read_frame(0, 1, 1);
      cur_tag = "R9";
      write_frame(1, 0);
      idle_wr(BLANK);
      read_frame(1, 0, 0);
      // R7: next table publishes mid-replay
      cur_tag = "R7";
      fork
         begin write_frame(2, 0); idle_wr(BLANK); end
         read_frame(1, 0, 12);
      join
      cur_tag = "R8";
      read_frame(2, 0, 0);
      repeat (5) @(negedge clk);
      // R3: one toggle per captured frame
      compared++;
      if (syncs != 3) begin
         mism++;
         $display("FAIL R3 toggle count: actual %0d expected 3", syncs);
      end
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            mism++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
      $finish;
   end

endmodule